// File: doc/BRIEF.md
# SD Host Data FIFO with Threshold Flag and Interrupt Status

This block sits between the processor's register port and the SD data-line engine of an SD host controller. A 16-word by 32-bit FIFO carries the payload. The transfer direction is selected by `xfer_rd_i`. On card reads the line side pushes words and the processor pops them through the data port. On card writes the processor pushes words and the line side pops them. The line side is modelled as plain push and pop strobes. Serialization and CRC generation are left to the engine.

A shared data flag tells software when a burst can be moved. In read direction it rises once enough words are held. In write direction it rises once enough space is free. Both thresholds are programmable, and they share a debug register with the live fill level. The block also keeps the host status register, whose error and event bits are cleared by writing one. A configuration register holds the interrupt enables. A block counter counts words moved on the line side and flags the end of each block.

Register word addresses: 0 data port, 1 status, 2 configuration, 3 debug, 4 block byte size, 5 remaining block count.

Top module: `sdx_fifo_core`

## Requirements
- R1: The FIFO returns words in the order they were accepted and holds up to 16. In read direction (`xfer_rd_i`=1) only `line_push_i` fills it and only processor reads of address 0 drain it. In write direction only processor writes of address 0 fill it and only `line_pop_i` drains it, with `line_rdata_o` showing the head word. Data-port writes in read direction are ignored.
- R2: The debug register (address 3) holds the fill level at bits 8:4, the write threshold at bits 13:9 and the read threshold at bits 18:14. Both thresholds are writable and reset to 4.
- R3: Some accesses are rejected: a pop while empty, or a push while full, from either side. A rejected access sets status bit 3 (FIFO error) and leaves the fill level and contents unchanged.
- R4: In read direction, status bit 0 (data flag) is 1 exactly when fill level >= read threshold.
- R5: In write direction, status bit 0 is 1 exactly when 16 minus fill level >= write threshold.
- R6: Writing the status register clears every stored bit written as 1 and leaves the others alone. If an event sets a bit in the same cycle it is cleared, the bit stays set.
- R7: Each event input sets its own status bit: `crc16_err_i` bit 5, `rw_tout_i` bit 7, `sdio_evt_i` bit 8, `busy_evt_i` bit 10.
- R8: A block is the byte size at address 4 divided by 4, counted in line-side words. The last accepted word of a block sets status bit 9 and decrements the block count at address 5. Once that count is 0, no further block events occur.
- R9: The configuration register (address 2) holds four enables: data at bit 4, SDIO at bit 5, block at bit 8 and busy at bit 10. `irq_o` = (data flag & bit 4) | (status bit 8 & bit 5) | (status bit 9 & bit 8) | (status bit 10 & bit 10). The error bits never raise `irq_o`.
- R10: After reset the FIFO is empty, all status bits and enables are 0, the block size and block count are 0, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops on the data port) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| xfer_rd_i | input | 1 | 1: card-to-host direction, 0: host-to-card |
| line_push_i | input | 1 | Line side delivers a word (read direction) |
| line_wdata_i | input | 32 | Word delivered by the line side |
| line_pop_i | input | 1 | Line side takes the head word (write direction) |
| line_rdata_o | output | 32 | Head word offered to the line side |
| crc16_err_i | input | 1 | Data CRC error event |
| rw_tout_i | input | 1 | Read/write timeout event |
| sdio_evt_i | input | 1 | SDIO interrupt event |
| busy_evt_i | input | 1 | Busy-release event |
| irq_o | output | 1 | Interrupt request |

## Verification
Every strobe and event is sampled on a rising edge. Its effect on fill level, status, data flag, block count and `irq_o` is visible right after that same edge, so one cycle after the strobe goes high. Read data on the data port is combinational and belongs to the cycle in which the read strobe is high. The bench drives all inputs on falling edges and holds each strobe across exactly one rising edge. It reads register values shortly after the following falling edge. A scoreboard monitor compares popped words on the rising edge where the pop is taken.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
  localparam int A_DATA  = 0;
  localparam int A_STS   = 1;
  localparam int A_CFG   = 2;
  localparam int A_DBG   = 3;
  localparam int A_BYTES = 4;
  localparam int A_BLKS  = 5;

  localparam int STS_W      = 11;
  localparam int S_FIFO_ERR = 3;
  localparam int S_CRC      = 5;
  localparam int S_TOUT     = 7;
  localparam int S_SDIO     = 8;
  localparam int S_BLK      = 9;
  localparam int S_BUSY     = 10;
  localparam logic [STS_W-1:0] STS_KEEP = STS_W'((1 << S_FIFO_ERR) | (1 << S_CRC) |
    (1 << S_TOUT) | (1 << S_SDIO) | (1 << S_BLK) | (1 << S_BUSY));

  localparam int C_DATA_EN = 4;
  localparam int C_SDIO_EN = 5;
  localparam int C_BLK_EN  = 8;
  localparam int C_BUSY_EN = 10;

  localparam int D_FILL_LSB = 4;
  localparam int D_WTH_LSB  = 9;
  localparam int D_RTH_LSB  = 14;
endpackage

// File: rtl/sdx_fifo_mem.sv
module sdx_fifo_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] fill_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] fill_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (fill_q == CW'(DEPTH));
  assign empty_o = (fill_q == '0);
  assign fill_o  = fill_q;
  assign head_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (push_i && !pop_i)      fill_q <= fill_q + 1'b1;
      else if (pop_i && !push_i) fill_q <= fill_q - 1'b1;
    end
  end
endmodule

// File: rtl/sdx_sts.sv
module sdx_sts #(
  parameter int SW = 11,
  parameter logic [SW-1:0] KEEP = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] set_i,
  input  logic [SW-1:0] clr_i,
  output logic [SW-1:0] sts_o
);
  logic [SW-1:0] sts_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= ((sts_q & ~clr_i) | set_i) & KEEP;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/sdx_blk_ctr.sv
module sdx_blk_ctr #(
  parameter int BW = 10,
  parameter int NW = 9,
  localparam int WW = BW - 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bytes_we_i,
  input  logic [BW-1:0] bytes_i,
  input  logic          blks_we_i,
  input  logic [NW-1:0] blks_i,
  input  logic          word_i,
  output logic [BW-1:0] bytes_o,
  output logic [NW-1:0] blks_o,
  output logic          done_o
);
  logic [BW-1:0] bytes_q;
  logic [NW-1:0] blks_q;
  logic [WW-1:0] word_q;
  logic [WW-1:0] words;
  logic          live, last;

  assign words  = bytes_q[BW-1:2];
  assign live   = (blks_q != '0) && (words != '0);
  assign last   = (word_q + 1'b1) == words;
  assign done_o = word_i && live && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bytes_q <= '0;
      blks_q  <= '0;
      word_q  <= '0;
    end else if (bytes_we_i) begin
      bytes_q <= bytes_i;
      word_q  <= '0;
    end else if (blks_we_i) begin
      blks_q  <= blks_i;
      word_q  <= '0;
    end else if (word_i && live) begin
      word_q <= last ? '0 : word_q + 1'b1;
      if (last) blks_q <= blks_q - 1'b1;
    end
  end

  assign bytes_o = bytes_q;
  assign blks_o  = blks_q;
endmodule

// File: rtl/sdx_fifo_core.sv
module sdx_fifo_core
  import sdx_pkg::*;
#(
  parameter int DW     = 32,
  parameter int DEPTH  = 16,
  parameter int AW     = 3,
  parameter int TW     = 5,
  parameter int TH_RST = 4,
  parameter int BW     = 10,
  parameter int NW     = 9,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          xfer_rd_i,
  input  logic          line_push_i,
  input  logic [DW-1:0] line_wdata_i,
  input  logic          line_pop_i,
  output logic [DW-1:0] line_rdata_o,
  input  logic          crc16_err_i,
  input  logic          rw_tout_i,
  input  logic          sdio_evt_i,
  input  logic          busy_evt_i,
  output logic          irq_o
);
  logic          wr_data, rd_data, wr_sts, wr_cfg, wr_dbg, wr_bytes, wr_blks;
  logic          push_req, pop_req, push_ok, pop_ok, fifo_err;
  logic [DW-1:0] push_data, head;
  logic [CW-1:0] fill;
  logic          full, empty, data_flag, blk_done, line_word;
  logic [TW-1:0] wr_th_q, rd_th_q;
  logic          en_data_q, en_sdio_q, en_blk_q, en_busy_q;
  logic [STS_W-1:0] sts_set, sts_clr, sts_q, sts_rd;
  logic [BW-1:0] bytes;
  logic [NW-1:0] blks;

  assign wr_data  = reg_wr_i && (reg_addr_i == AW'(A_DATA));
  assign rd_data  = reg_rd_i && (reg_addr_i == AW'(A_DATA));
  assign wr_sts   = reg_wr_i && (reg_addr_i == AW'(A_STS));
  assign wr_cfg   = reg_wr_i && (reg_addr_i == AW'(A_CFG));
  assign wr_dbg   = reg_wr_i && (reg_addr_i == AW'(A_DBG));
  assign wr_bytes = reg_wr_i && (reg_addr_i == AW'(A_BYTES));
  assign wr_blks  = reg_wr_i && (reg_addr_i == AW'(A_BLKS));

  // direction picks which side fills and which side drains
  assign push_req  = xfer_rd_i ? line_push_i  : wr_data;
  assign pop_req   = xfer_rd_i ? rd_data      : line_pop_i;
  assign push_data = xfer_rd_i ? line_wdata_i : reg_wdata_i;
  assign push_ok   = push_req && !full;
  assign pop_ok    = pop_req && !empty;
  assign fifo_err  = (push_req && full) || (pop_req && empty);
  assign line_word = xfer_rd_i ? push_ok : pop_ok;

  sdx_fifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk_i, .rst_ni,
    .push_i(push_ok), .push_data_i(push_data), .pop_i(pop_ok),
    .head_o(head), .fill_o(fill), .full_o(full), .empty_o(empty)
  );

  assign line_rdata_o = head;

  assign data_flag = xfer_rd_i ? (32'(fill) >= 32'(rd_th_q))
                               : ((32'(DEPTH) - 32'(fill)) >= 32'(wr_th_q));

  sdx_blk_ctr #(.BW(BW), .NW(NW)) u_blk (
    .clk_i, .rst_ni,
    .bytes_we_i(wr_bytes), .bytes_i(reg_wdata_i[BW-1:0]),
    .blks_we_i(wr_blks), .blks_i(reg_wdata_i[NW-1:0]),
    .word_i(line_word), .bytes_o(bytes), .blks_o(blks), .done_o(blk_done)
  );

  always_comb begin
    sts_set             = '0;
    sts_set[S_FIFO_ERR] = fifo_err;
    sts_set[S_CRC]      = crc16_err_i;
    sts_set[S_TOUT]     = rw_tout_i;
    sts_set[S_SDIO]     = sdio_evt_i;
    sts_set[S_BLK]      = blk_done;
    sts_set[S_BUSY]     = busy_evt_i;
  end

  assign sts_clr = wr_sts ? reg_wdata_i[STS_W-1:0] : '0;

  sdx_sts #(.SW(STS_W), .KEEP(STS_KEEP)) u_sts (
    .clk_i, .rst_ni, .set_i(sts_set), .clr_i(sts_clr), .sts_o(sts_q)
  );

  assign sts_rd = sts_q | {{(STS_W-1){1'b0}}, data_flag};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_data_q <= 1'b0;
      en_sdio_q <= 1'b0;
      en_blk_q  <= 1'b0;
      en_busy_q <= 1'b0;
      wr_th_q   <= TW'(TH_RST);
      rd_th_q   <= TW'(TH_RST);
    end else begin
      if (wr_cfg) begin
        en_data_q <= reg_wdata_i[C_DATA_EN];
        en_sdio_q <= reg_wdata_i[C_SDIO_EN];
        en_blk_q  <= reg_wdata_i[C_BLK_EN];
        en_busy_q <= reg_wdata_i[C_BUSY_EN];
      end
      if (wr_dbg) begin
        wr_th_q <= reg_wdata_i[D_WTH_LSB +: TW];
        rd_th_q <= reg_wdata_i[D_RTH_LSB +: TW];
      end
    end
  end

  assign irq_o = (data_flag && en_data_q) || (sts_q[S_SDIO] && en_sdio_q) ||
                 (sts_q[S_BLK] && en_blk_q) || (sts_q[S_BUSY] && en_busy_q);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      AW'(A_DATA):  reg_rdata_o = empty ? '0 : head;
      AW'(A_STS):   reg_rdata_o[STS_W-1:0] = sts_rd;
      AW'(A_CFG): begin
        reg_rdata_o[C_DATA_EN] = en_data_q;
        reg_rdata_o[C_SDIO_EN] = en_sdio_q;
        reg_rdata_o[C_BLK_EN]  = en_blk_q;
        reg_rdata_o[C_BUSY_EN] = en_busy_q;
      end
      AW'(A_DBG): begin
        reg_rdata_o[D_FILL_LSB +: CW] = fill;
        reg_rdata_o[D_WTH_LSB +: TW]  = wr_th_q;
        reg_rdata_o[D_RTH_LSB +: TW]  = rd_th_q;
      end
      AW'(A_BYTES): reg_rdata_o[BW-1:0] = bytes;
      AW'(A_BLKS):  reg_rdata_o[NW-1:0] = blks;
      default: ;
    endcase
  end
endmodule

// File: rtl/sdx_fifo_core_chk.sv
module sdx_fifo_core_chk
  import sdx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_req,
  input logic             pop_req,
  input logic [CW-1:0]    fill,
  input logic [STS_W-1:0] sts_q,
  input logic [STS_W-1:0] sts_set,
  input logic [STS_W-1:0] sts_clr,
  input logic             blk_done,
  input logic             any_en,
  input logic             irq_o
);
  assert_fill_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(fill) <= DEPTH);

  assert_fill_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (fill == $past(fill)) || (fill == $past(fill) + 1'b1) ||
             (fill + 1'b1 == $past(fill)));

  assert_underflow_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_req && fill == '0) |=> sts_q[S_FIFO_ERR]);

  assert_underflow_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_req && !push_req && fill == '0) |=> (fill == '0));

  assert_overflow_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req && fill == CW'(DEPTH)) |=> sts_q[S_FIFO_ERR]);

  assert_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sts_clr & ~sts_set)) |=> ((sts_q & $past(sts_clr & ~sts_set)) == '0));

  assert_blk_event_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_done |=> sts_q[S_BLK]);

  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_en |-> !irq_o);
endmodule

bind sdx_fifo_core sdx_fifo_core_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .push_req (push_req),
  .pop_req  (pop_req),
  .fill     (fill),
  .sts_q    (sts_q),
  .sts_set  (sts_set),
  .sts_clr  (sts_clr),
  .blk_done (blk_done),
  .any_en   (en_data_q || en_sdio_q || en_blk_q || en_busy_q),
  .irq_o    (irq_o)
);

// File: tb/tb_sdx_fifo_core.sv
module tb_sdx_fifo_core;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        xfer_rd_i = 1'b1;
  logic        line_push_i = 1'b0, line_pop_i = 1'b0;
  logic [31:0] line_wdata_i = '0, line_rdata_o;
  logic        crc16_err_i = 1'b0, rw_tout_i = 1'b0, sdio_evt_i = 1'b0, busy_evt_i = 1'b0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];

  sdx_fifo_core dut (
    .clk_i, .rst_ni, .reg_wr_i, .reg_rd_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .xfer_rd_i, .line_push_i, .line_wdata_i, .line_pop_i, .line_rdata_o,
    .crc16_err_i, .rw_tout_i, .sdio_evt_i, .busy_evt_i, .irq_o
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  // scoreboard monitor: compares every pop as it is taken
  always @(posedge clk_i) begin
    if (rst_ni && xfer_rd_i && reg_rd_i && reg_addr_i == 3'd0 && exp_q.size() > 0)
      chk("R1", "cpu pop order", reg_rdata_o, exp_q.pop_front());
    if (rst_ni && !xfer_rd_i && line_pop_i && exp_q.size() > 0)
      chk("R1", "line pop order", line_rdata_o, exp_q.pop_front());
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    if (a == 3'd0 && !xfer_rd_i && exp_q.size() < DEPTH) exp_q.push_back(d);
    @(posedge clk_i); #1 reg_wr_i = 1'b0;
  endtask

  task automatic cpu_pop();
    @(negedge clk_i);
    reg_rd_i = 1'b1; reg_addr_i = 3'd0;
    @(posedge clk_i); #1 reg_rd_i = 1'b0;
  endtask

  task automatic line_push(input logic [31:0] d);
    @(negedge clk_i);
    line_push_i = 1'b1; line_wdata_i = d;
    if (xfer_rd_i && exp_q.size() < DEPTH) exp_q.push_back(d);
    @(posedge clk_i); #1 line_push_i = 1'b0;
  endtask

  task automatic line_pop();
    @(negedge clk_i);
    line_pop_i = 1'b1;
    @(posedge clk_i); #1 line_pop_i = 1'b0;
  endtask

  task automatic peek(input string req, input string what, input logic [2:0] a,
                      input logic [31:0] exp);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 chk(req, what, reg_rdata_o, exp);
  endtask

  task automatic irq_is(input string req, input logic exp);
    @(negedge clk_i);
    #1 chk(req, "irq_o", {31'd0, irq_o}, {31'd0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R10 reset state
    peek("R10", "status", 3'd1, 32'h0);
    peek("R2", "debug reset", 3'd3, 32'h0001_0800);
    peek("R10", "config", 3'd2, 32'h0);
    peek("R10", "block count", 3'd5, 32'h0);
    irq_is("R10", 1'b0);

    // R4 read-direction threshold
    for (int i = 0; i < 3; i++) line_push(32'hA000_0000 + i);
    peek("R4", "flag below rd threshold", 3'd1, 32'h0);
    peek("R2", "fill 3", 3'd3, 32'h0001_0830);
    line_push(32'hA000_0003);
    peek("R4", "flag at rd threshold", 3'd1, 32'h1);
    irq_is("R9", 1'b0);
    reg_wr(3'd2, 32'h10);
    peek("R9", "config readback", 3'd2, 32'h10);
    irq_is("R9", 1'b1);
    for (int i = 0; i < 4; i++) cpu_pop();
    peek("R4", "drained", 3'd1, 32'h0);
    irq_is("R9", 1'b0);

    // R3 underflow
    cpu_pop();
    peek("R3", "underflow error", 3'd1, 32'h8);
    peek("R3", "fill after underflow", 3'd3, 32'h0001_0800);
    irq_is("R9", 1'b0);

    // R6 write-one-to-clear
    reg_wr(3'd1, 32'h0);
    peek("R6", "zero write keeps", 3'd1, 32'h8);
    reg_wr(3'd1, 32'h8);
    peek("R6", "one clears", 3'd1, 32'h0);

    // R1 data-port write in read direction is ignored
    reg_wr(3'd0, 32'hDEAD_BEEF);
    peek("R1", "wrong-direction write", 3'd3, 32'h0001_0800);

    // R2 threshold update: read 2, write 4
    reg_wr(3'd3, 32'h0000_8800);
    line_push(32'hB000_0000);
    peek("R4", "below rd th 2", 3'd1, 32'h0);
    line_push(32'hB000_0001);
    peek("R4", "at rd th 2", 3'd1, 32'h1);
    cpu_pop(); cpu_pop();

    // R5 write direction
    xfer_rd_i = 1'b0;
    peek("R5", "empty has space", 3'd1, 32'h1);
    for (int i = 0; i < 12; i++) reg_wr(3'd0, 32'hC000_0000 + i);
    peek("R5", "free 4", 3'd1, 32'h1);
    reg_wr(3'd0, 32'hC000_000C);
    peek("R5", "free 3", 3'd1, 32'h0);
    for (int i = 13; i < 16; i++) reg_wr(3'd0, 32'hC000_0000 + i);
    peek("R2", "fill 16", 3'd3, 32'h0000_8900);
    reg_wr(3'd0, 32'hFFFF_FFFF);
    peek("R3", "overflow error", 3'd1, 32'h8);
    peek("R3", "fill after overflow", 3'd3, 32'h0000_8900);
    reg_wr(3'd1, 32'h8);
    for (int i = 0; i < 16; i++) line_pop();
    peek("R5", "empty after pops", 3'd1, 32'h1);
    line_pop();
    peek("R3", "line underflow", 3'd1, 32'h9);
    reg_wr(3'd1, 32'h8);

    // R7 events, R9 gating
    @(negedge clk_i);
    crc16_err_i = 1'b1; rw_tout_i = 1'b1; sdio_evt_i = 1'b1; busy_evt_i = 1'b1;
    @(posedge clk_i); #1;
    crc16_err_i = 1'b0; rw_tout_i = 1'b0; sdio_evt_i = 1'b0; busy_evt_i = 1'b0;
    peek("R7", "event bits", 3'd1, 32'h5A1);
    irq_is("R9", 1'b1);
    reg_wr(3'd2, 32'h0);
    irq_is("R9", 1'b0);
    reg_wr(3'd2, 32'h400);
    irq_is("R9", 1'b1);
    reg_wr(3'd2, 32'h20);
    irq_is("R9", 1'b1);
    reg_wr(3'd1, 32'h500);
    peek("R6", "partial clear", 3'd1, 32'hA1);
    irq_is("R9", 1'b0);
    reg_wr(3'd1, 32'hA0);
    reg_wr(3'd2, 32'h0);

    // R6 set wins over clear
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = 3'd1; reg_wdata_i = 32'h20; crc16_err_i = 1'b1;
    @(posedge clk_i); #1 reg_wr_i = 1'b0; crc16_err_i = 1'b0;
    peek("R6", "set wins", 3'd1, 32'h21);
    reg_wr(3'd1, 32'h20);

    // R8 block counting
    xfer_rd_i = 1'b1;
    reg_wr(3'd4, 32'd16);
    reg_wr(3'd5, 32'd2);
    reg_wr(3'd2, 32'h100);
    peek("R8", "byte size", 3'd4, 32'd16);
    for (int i = 0; i < 3; i++) line_push(32'hD000_0000 + i);
    peek("R8", "mid block", 3'd1, 32'h1);
    line_push(32'hD000_0003);
    peek("R8", "first block done", 3'd1, 32'h201);
    peek("R8", "blocks left 1", 3'd5, 32'd1);
    irq_is("R9", 1'b1);
    for (int i = 0; i < 4; i++) cpu_pop();
    reg_wr(3'd1, 32'h200);
    irq_is("R8", 1'b0);
    for (int i = 0; i < 4; i++) line_push(32'hE000_0000 + i);
    peek("R8", "second block done", 3'd1, 32'h201);
    peek("R8", "blocks left 0", 3'd5, 32'd0);
    for (int i = 0; i < 4; i++) cpu_pop();
    reg_wr(3'd1, 32'h200);
    for (int i = 0; i < 4; i++) line_push(32'hF000_0000 + i);
    peek("R8", "no event at zero", 3'd1, 32'h1);
    peek("R8", "count stays 0", 3'd5, 32'd0);
    for (int i = 0; i < 4; i++) cpu_pop();
    chk("R1", "scoreboard empty", 32'(exp_q.size()), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule